// File: doc/BRIEF.md
# Display Link Mode Arbiter

This block decides which of three link modes a display identification memory is in. After power-up it is in streaming mode, where a separate streamer shifts out the memory contents on every rising edge of the stream clock. A falling edge on the serial clock line (SCL) of the two-wire bus hints that a host wants to talk, so the block moves into a transition mode. In that mode the two-wire slave logic listens for its control byte while the block counts stream-clock pulses as a recovery watchdog.

When the slave front end reports a matching control byte (address pattern 1010000 with either direction bit), the block latches into bidirectional mode and stays there until reset. Reset stands in for removing power. If instead 128 stream-clock pulses arrive while SCL sits high with no falling edge, the block falls back to streaming mode and pulses a restart so the streamer begins again at address zero. Every falling edge on SCL clears the pulse count. In bidirectional mode the stream clock no longer clocks anything; its level only gates writes.

The states are named STREAM, TRANS and BIDIR. The transitions are named: SCL fall (STREAM to TRANS), byte match (TRANS to BIDIR), recovery (TRANS to STREAM) and reset (any state to STREAM).

Top module: `mode_latch_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `link_mode` is STREAM (encoding 0), `stream_en` is 1, and `slave_en`, `wr_en` and `stream_restart` are 0.
- R2: In STREAM, a falling edge on `scl_in` moves `link_mode` to TRANS (encoding 1) one clock later. Stream-clock pulses alone leave the mode at STREAM.
- R3: In TRANS, each rising edge of `sclk_in` adds one to the recovery count, and a falling edge on `scl_in` clears it. 127 pulses after the last clear keep the mode at TRANS.
- R4: In TRANS, once the count has reached 128 and `scl_in` is high, the next clock edge returns the mode to STREAM. In that same edge `stream_restart` goes high for exactly one cycle.
- R5: In TRANS, `ctrl_hit` moves the mode to BIDIR (encoding 2) at the next edge. It wins over a recovery that is due in the same cycle.
- R6: BIDIR is left only through reset. SCL edges, stream-clock pulses and `ctrl_hit` do not change the mode.
- R7: `wr_en` equals the `sclk_in` level while in BIDIR and is 0 in STREAM and TRANS.
- R8: `stream_en` is 1 exactly in STREAM. `slave_en` is 1 exactly in TRANS and BIDIR.
- R9: The recovery count saturates instead of wrapping. When pulses arrive while `scl_in` is held low, recovery is held off. It fires on the first edge at which `scl_in` is high again.
- R10: `ctrl_hit` in STREAM has no effect; the mode stays STREAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, stands in for power-up |
| scl_in | input | 1 | Synchronized two-wire bus clock line |
| sclk_in | input | 1 | Synchronized stream clock |
| ctrl_hit | input | 1 | One-cycle strobe from the slave front end: own control byte received |
| link_mode | output | 2 | Current mode: 0 STREAM, 1 TRANS, 2 BIDIR |
| stream_en | output | 1 | Enable for the streamer |
| slave_en | output | 1 | Enable for the two-wire slave |
| wr_en | output | 1 | Write permission for the slave, from the stream-clock level in BIDIR |
| stream_restart | output | 1 | One-cycle pulse telling the streamer to restart at address zero |

## Verification
The bench first stops the count one pulse short of 128 and confirms the mode holds. A design that fires at 127 or at the wrong edge would drop back to streaming too early. It then clears the count partway through with an SCL fall, which catches a watchdog that ignores SCL and would recover early. It sends 300 pulses while SCL is held low, which catches a wrapping counter that would never recover. A control byte arriving in the same cycle as a due recovery catches a design that gives recovery the higher priority and loses the bus. Stimulus in BIDIR and a strobe in STREAM catch a latch that can be undone, or a mode that can be entered without passing through TRANS.

// File: rtl/mode_latch_pkg.sv
package mode_latch_pkg;

    typedef enum logic [1:0] {
        ML_STREAM = 2'd0,
        ML_TRANS  = 2'd1,
        ML_BIDIR  = 2'd2
    } link_mode_e;

    localparam int unsigned RECOVER_PULSES = 128;

endpackage

// File: rtl/line_edge_det.sv
module line_edge_det #(
    parameter bit IDLE_LVL    = 1'b1,
    parameter bit DETECT_FALL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);

    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= IDLE_LVL;
        end else begin
            lvl_q <= lvl;
        end
    end

    generate
        if (DETECT_FALL) begin : g_fall
            assign pulse = lvl_q & ~lvl;
        end else begin : g_rise
            assign pulse = ~lvl_q & lvl;
        end
    endgenerate

endmodule

// File: rtl/pulse_watchdog.sv
module pulse_watchdog #(
    parameter int unsigned LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic expired
);

    localparam int unsigned CNT_W = $clog2(LIMIT) + 1;
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] SAT_V = '1;

    logic [CNT_W-1:0] cnt_q;

    // Saturating count: once full it holds, so a long run never wraps below the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step && (cnt_q != SAT_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= LIM_V);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import mode_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_fall,
    input  logic       scl_lvl,
    input  logic       hit,
    input  logic       expired,
    output link_mode_e state,
    output logic       restart
);

    link_mode_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ML_STREAM;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ML_STREAM: begin
                if (scl_fall) begin
                    nxt = ML_TRANS;          // SCL fall
                end
            end
            ML_TRANS: begin
                if (hit) begin
                    nxt = ML_BIDIR;          // byte match, wins over recovery
                end else if (expired && scl_lvl) begin
                    nxt = ML_STREAM;         // recovery
                end
            end
            ML_BIDIR: begin
                nxt = ML_BIDIR;              // latched until reset
            end
            default: begin
                nxt = ML_STREAM;
            end
        endcase
    end

    // Output register: restart pulse coincides with the return to STREAM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart <= 1'b0;
        end else begin
            restart <= (state == ML_TRANS) && (nxt == ML_STREAM);
        end
    end

endmodule

// File: rtl/mode_latch_ctrl.sv
module mode_latch_ctrl
    import mode_latch_pkg::*;
#(
    parameter int unsigned RECOVER_CNT = RECOVER_PULSES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sclk_in,
    input  logic       ctrl_hit,
    output logic [1:0] link_mode,
    output logic       stream_en,
    output logic       slave_en,
    output logic       wr_en,
    output logic       stream_restart
);

    link_mode_e state;
    logic       scl_fall;
    logic       sclk_rise;
    logic       wd_clear;
    logic       wd_step;
    logic       wd_expired;
    logic       in_trans;

    line_edge_det #(
        .IDLE_LVL    (1'b1),
        .DETECT_FALL (1'b1)
    ) u_scl_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (scl_in),
        .pulse (scl_fall)
    );

    line_edge_det #(
        .IDLE_LVL    (1'b1),
        .DETECT_FALL (1'b0)
    ) u_sclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_in),
        .pulse (sclk_rise)
    );

    assign in_trans = (state == ML_TRANS);
    assign wd_clear = !in_trans || scl_fall;
    assign wd_step  = in_trans && sclk_rise;

    pulse_watchdog #(
        .LIMIT (RECOVER_CNT)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wd_clear),
        .step    (wd_step),
        .expired (wd_expired)
    );

    mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_fall (scl_fall),
        .scl_lvl  (scl_in),
        .hit      (ctrl_hit),
        .expired  (wd_expired),
        .state    (state),
        .restart  (stream_restart)
    );

    always_comb begin
        link_mode = state;
        stream_en = (state == ML_STREAM);
        slave_en  = (state != ML_STREAM);
        wr_en     = (state == ML_BIDIR) && sclk_in;
    end

endmodule

// File: rtl/mode_latch_chk.sv
module mode_latch_chk
    import mode_latch_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sclk_in,
    input logic       ctrl_hit,
    input logic [1:0] link_mode,
    input logic       stream_en,
    input logic       slave_en,
    input logic       wr_en,
    input logic       stream_restart
);

    a_r2_fall_enters_trans: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == ML_STREAM && $fell(scl_in)) |=> (link_mode == ML_TRANS));

    a_r3_fall_blocks_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == ML_TRANS && $fell(scl_in)) |=> (link_mode != ML_STREAM));

    a_r4_restart_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        stream_restart |-> (link_mode == ML_STREAM && $past(link_mode) == ML_TRANS));

    a_r5_hit_enters_bidir: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == ML_TRANS && ctrl_hit) |=> (link_mode == ML_BIDIR));

    a_r6_bidir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == ML_BIDIR) |=> (link_mode == ML_BIDIR));

    a_r7_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (link_mode == ML_BIDIR && sclk_in));

    a_r8_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({stream_en, slave_en}) == 1);

    a_r9_low_scl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == ML_TRANS && !scl_in) |=> (link_mode != ML_STREAM));

    a_r10_stream_ignores_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == ML_STREAM && scl_in && ctrl_hit) |=> (link_mode != ML_BIDIR));

endmodule

bind mode_latch_ctrl mode_latch_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_in         (scl_in),
    .sclk_in        (sclk_in),
    .ctrl_hit       (ctrl_hit),
    .link_mode      (link_mode),
    .stream_en      (stream_en),
    .slave_en       (slave_en),
    .wr_en          (wr_en),
    .stream_restart (stream_restart)
);

// File: tb/mode_latch_ctrl_tb.sv
module mode_latch_ctrl_tb;

    localparam time CLK_P = 10ns;
    localparam int  NVEC  = 9;

    // Vector fields: [5] scl, [4] sclk, [3] hit, [2:1] expected mode, [0] expected wr_en
    localparam logic [5:0] VEC [NVEC] = '{
        6'b1_0_0_00_0,   // R1 idle stream
        6'b1_1_0_00_0,   // R2 stream clock alone keeps STREAM
        6'b0_0_0_01_0,   // R2 SCL fall -> TRANS
        6'b1_0_0_01_0,   // R2 SCL rise no effect
        6'b1_1_0_01_0,   // R7 no write in TRANS
        6'b1_0_1_10_0,   // R5 hit -> BIDIR
        6'b1_1_0_10_1,   // R7 write follows stream clock
        6'b0_0_1_10_0,   // R6 fall and hit in BIDIR
        6'b1_1_0_10_1    // R6 still BIDIR
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1;
    logic       sclk_in = 1'b0;
    logic       ctrl_hit = 1'b0;
    logic [1:0] link_mode;
    logic       stream_en;
    logic       slave_en;
    logic       wr_en;
    logic       stream_restart;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    mode_latch_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_in         (scl_in),
        .sclk_in        (sclk_in),
        .ctrl_hit       (ctrl_hit),
        .link_mode      (link_mode),
        .stream_en      (stream_en),
        .slave_en       (slave_en),
        .wr_en          (wr_en),
        .stream_restart (stream_restart)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        scl_in = 1'b1;
        sclk_in = 1'b0;
        ctrl_hit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sclk_in = 1'b1;
            @(negedge clk);
            sclk_in = 1'b0;
        end
    endtask

    task automatic scl_dip();
        @(negedge clk);
        scl_in = 1'b0;
        @(negedge clk);
        scl_in = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        check("R1 mode in reset", link_mode, 0);
        check("R1 stream_en in reset", stream_en, 1);
        do_reset();
        check("R1 mode", link_mode, 0);
        check("R1 stream_en", stream_en, 1);
        check("R1 slave_en", slave_en, 0);
        check("R1 wr_en", wr_en, 0);
        check("R1 restart", stream_restart, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            scl_in   = VEC[i][5];
            sclk_in  = VEC[i][4];
            ctrl_hit = VEC[i][3];
            @(negedge clk);
            check($sformatf("R2/R5/R6 vec %0d mode", i), link_mode, VEC[i][2:1]);
            check($sformatf("R7 vec %0d wr_en", i), wr_en, VEC[i][0]);
            check($sformatf("R8 vec %0d slave_en", i), slave_en, VEC[i][2:1] != 2'd0);
        end
        ctrl_hit = 1'b0;
        sclk_in = 1'b0;
        scl_in = 1'b1;

        // R3/R4: one short of the limit, clear by SCL fall, then the full count
        do_reset();
        scl_dip();
        @(negedge clk);
        check("R2 enter TRANS", link_mode, 1);
        pulses(127);
        repeat (2) @(negedge clk);
        check("R3 127 pulses hold TRANS", link_mode, 1);
        scl_dip();
        pulses(127);
        repeat (2) @(negedge clk);
        check("R3 fall cleared count", link_mode, 1);
        pulses(1);
        check("R4 count reached, not yet returned", link_mode, 1);
        @(negedge clk);
        check("R4 returned to STREAM", link_mode, 0);
        check("R4 restart pulse", stream_restart, 1);
        check("R8 stream_en after recovery", stream_en, 1);
        @(negedge clk);
        check("R4 restart one cycle", stream_restart, 0);

        // R5 priority of byte match over due recovery
        scl_dip();
        pulses(128);
        ctrl_hit = 1'b1;
        @(negedge clk);
        ctrl_hit = 1'b0;
        check("R5 hit beats recovery", link_mode, 2);
        check("R5 no restart", stream_restart, 0);

        // R6 sticky BIDIR, R7 write level
        pulses(130);
        scl_dip();
        @(negedge clk);
        check("R6 BIDIR after pulses and fall", link_mode, 2);
        sclk_in = 1'b1;
        @(negedge clk);
        check("R7 wr_en high", wr_en, 1);
        sclk_in = 1'b0;
        do_reset();
        check("R6 reset clears BIDIR", link_mode, 0);

        // R10 strobe in STREAM ignored
        ctrl_hit = 1'b1;
        @(negedge clk);
        ctrl_hit = 1'b0;
        @(negedge clk);
        check("R10 hit in STREAM", link_mode, 0);

        // R9 saturation with SCL held low
        @(negedge clk);
        scl_in = 1'b0;
        pulses(300);
        repeat (2) @(negedge clk);
        check("R9 low SCL holds TRANS", link_mode, 1);
        scl_in = 1'b1;
        @(negedge clk);
        check("R9 recovery on SCL high", link_mode, 0);
        check("R9 restart", stream_restart, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule